// File: doc/BRIEF.md
# Interrupt Controller Register Port

This block is the software-facing register file of a small interrupt controller with `N_SRC` sources (ID 0 meaning "no interrupt") and `N_TGT` targets. It stores one priority per source, shared by every target, an enable bit array for each target, and a threshold for each target. It also holds one software-interrupt bit per target and offers a read-only view of the gateway pending bits. The stored values leave the block as flat vectors that feed the arbitration logic. That logic returns, for each target, the best enabled pending ID on `best_id_i`.

Each target also owns a claim/complete word, and both accesses to it have side effects. A read returns that target's best ID and, when the ID is non-zero, raises a claim pulse tagged with that ID in the same cycle as the read strobe. The gateway therefore clears the pending bit on the next clock edge. A write of a valid ID raises a completion pulse tagged with the written ID. The bus is a plain one-cycle port: write data is stored on the clock edge, and read data is combinational and valid while the read strobe is high.

The address map is in words. With the defaults (`N_SRC`=40, `N_TGT`=2, `MAX_PRIO`=7, `AW`=6) the regions sit as follows. Priorities are at 0..39. Enables are at 40..43, with E=ceil(N_SRC/32)=2 words per target. Thresholds are at 44..45 and claim/complete at 46..47. Software interrupts are at 48..49 and pending at 50..51. Addresses 52..63 are unmapped. In general, the regions follow each other in that order, starting at 0.

Top module: `irqc_regs`

## Requirements
- R1: After reset, every priority, enable, threshold and software-interrupt bit is 0 on `prio_o`, `enable_o`, `thresh_o` and `swi_o`, and reads of those registers return 0.
- R2: Word k (0 <= k < N_SRC) holds the priority of source k. Only the low PRIO_W=clog2(MAX_PRIO+1) bits of the write data are stored. A read returns them zero-extended, and `prio_o[k*PRIO_W +: PRIO_W]` carries them one cycle after the write.
- R3: The enable bit for source s of target t is bit s%32 of word N_SRC + E*t + (s>>5). It appears on `enable_o[t*N_SRC+s]`. Bits whose source number would be N_SRC or more are not stored and read as 0.
- R4: Word N_SRC + E*N_TGT + t holds the threshold of target t in its low PRIO_W bits. It appears on `thresh_o[t*PRIO_W +: PRIO_W]` and reads back zero-extended.
- R5: Pending word w (base N_SRC + E*N_TGT + 3*N_TGT) returns `pend_i[32*w+b]` in bit b, with 0 for bits past N_SRC-1. Writes to it change nothing.
- R6: A read of claim/complete word t (base N_SRC + E*N_TGT + N_TGT) returns `best_id_i` slice t. If that ID is non-zero, `claim_o[t]` is high in the same cycle and `claim_id_o` slice t equals it.
- R7: A claim read that finds ID 0 returns 0 and raises no claim pulse.
- R8: A write to claim/complete word t raises `complete_o[t]` in the same cycle, with `complete_id_o` slice t equal to the write data, only if the whole data word is between 1 and N_SRC-1. Other values raise no pulse. Such a write changes no stored register.
- R9: Bit 0 of word N_SRC + E*N_TGT + 2*N_TGT + t is the software-interrupt bit of target t. It drives `swi_o[t]` and reads back in bit 0, with the upper bits 0.
- R10: Reads of unmapped addresses return 0, and writes to them change no register.
- R11: With no strobe, the read data is 0, no claim or completion pulse is raised and no register changes. A read of any word other than a claim/complete word has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe |
| reg_re_i | input | 1 | Read strobe |
| reg_addr_i | input | AW | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with the read strobe |
| pend_i | input | N_SRC | Pending bits from the gateways |
| best_id_i | input | N_TGT*ID_W | Best enabled pending ID per target, from arbitration |
| prio_o | output | N_SRC*PRIO_W | Priority of each source |
| enable_o | output | N_TGT*N_SRC | Enable bit per target and source |
| thresh_o | output | N_TGT*PRIO_W | Threshold per target |
| swi_o | output | N_TGT | Software-interrupt bit per target |
| claim_o | output | N_TGT | Claim pulse per target |
| claim_id_o | output | N_TGT*ID_W | ID being claimed, per target |
| complete_o | output | N_TGT | Completion pulse per target |
| complete_id_o | output | N_TGT*ID_W | ID being completed, per target |

## Verification
A stored register that holds a wrong value shows up on its configuration output at the very next falling edge, because all four configuration vectors are compared with the model on every clock. A wrong decode, such as a write landing in the wrong word or an enable bit in the wrong position, shows up one cycle after the faulty write. It also shows up in the same cycle as any later read of that word. A claim or completion pulse that is missing, extra, or tagged with the wrong ID is caught in the very cycle of the strobe, because the pulses are combinational.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_PRIO,
      REG_ENAB,
      REG_THRS,
      REG_CLCO,
      REG_SWIR,
      REG_PEND
   } reg_region_e;

   function automatic int en_words(int n_src);
      return (n_src + 31) / 32;
   endfunction

   function automatic int en_base(int n_src);
      return n_src;
   endfunction

   function automatic int thr_base(int n_src, int n_tgt);
      return en_base(n_src) + n_tgt * en_words(n_src);
   endfunction

   function automatic int cc_base(int n_src, int n_tgt);
      return thr_base(n_src, n_tgt) + n_tgt;
   endfunction

   function automatic int swi_base(int n_src, int n_tgt);
      return cc_base(n_src, n_tgt) + n_tgt;
   endfunction

   function automatic int pend_base(int n_src, int n_tgt);
      return swi_base(n_src, n_tgt) + n_tgt;
   endfunction

   function automatic int map_end(int n_src, int n_tgt);
      return pend_base(n_src, n_tgt) + en_words(n_src);
   endfunction

   // bits of enable/pending word 'word' that correspond to real sources
   function automatic logic [31:0] word_mask(int n_src, int word);
      logic [31:0] m;
      for (int b = 0; b < 32; b++) begin
         m[b] = ((word * 32 + b) < n_src);
      end
      return m;
   endfunction

endpackage

// File: rtl/irqc_addr_map.sv
`timescale 1ns/1ps
module irqc_addr_map
   import irqc_pkg::*;
#(
   parameter int N_SRC = 40,
   parameter int N_TGT = 2,
   parameter int AW    = 6
) (
   input  logic [AW-1:0] addr_i,
   output reg_region_e   region_o,
   output logic [AW-1:0] offs_o
);

   localparam int EN_B   = en_base(N_SRC);
   localparam int THR_B  = thr_base(N_SRC, N_TGT);
   localparam int CC_B   = cc_base(N_SRC, N_TGT);
   localparam int SWI_B  = swi_base(N_SRC, N_TGT);
   localparam int PEND_B = pend_base(N_SRC, N_TGT);
   localparam int END_A  = map_end(N_SRC, N_TGT);

   logic [31:0] a;
   assign a = 32'(addr_i);

   always_comb begin
      region_o = REG_NONE;
      offs_o   = '0;
      if (a < 32'(EN_B)) begin
         region_o = REG_PRIO;
         offs_o   = AW'(a);
      end else if (a < 32'(THR_B)) begin
         region_o = REG_ENAB;
         offs_o   = AW'(a - 32'(EN_B));
      end else if (a < 32'(CC_B)) begin
         region_o = REG_THRS;
         offs_o   = AW'(a - 32'(THR_B));
      end else if (a < 32'(SWI_B)) begin
         region_o = REG_CLCO;
         offs_o   = AW'(a - 32'(CC_B));
      end else if (a < 32'(PEND_B)) begin
         region_o = REG_SWIR;
         offs_o   = AW'(a - 32'(SWI_B));
      end else if (a < 32'(END_A)) begin
         region_o = REG_PEND;
         offs_o   = AW'(a - 32'(PEND_B));
      end
   end

endmodule

// File: rtl/irqc_cfg_store.sv
`timescale 1ns/1ps
module irqc_cfg_store
   import irqc_pkg::*;
#(
   parameter int N_SRC  = 40,
   parameter int N_TGT  = 2,
   parameter int PRIO_W = 3,
   parameter int AW     = 6
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_i,
   input  reg_region_e               region_i,
   input  logic [AW-1:0]             offs_i,
   input  logic [31:0]               wdata_i,
   output logic [31:0]               cfg_rdata_o,
   output logic [N_SRC*PRIO_W-1:0]   prio_o,
   output logic [N_TGT*N_SRC-1:0]    enable_o,
   output logic [N_TGT*PRIO_W-1:0]   thresh_o,
   output logic [N_TGT-1:0]          swi_o
);

   localparam int EW     = en_words(N_SRC);
   localparam int EN_CNT = N_TGT * EW;

   logic [PRIO_W-1:0] prio_q [N_SRC];
   logic [31:0]       en_q   [EN_CNT];
   logic [PRIO_W-1:0] thr_q  [N_TGT];
   logic [N_TGT-1:0]  swi_q;

   for (genvar s = 0; s < N_SRC; s++) begin : g_prio
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            prio_q[s] <= '0;
         end else if (wr_i && region_i == REG_PRIO && offs_i == AW'(s)) begin
            prio_q[s] <= wdata_i[PRIO_W-1:0];
         end
      end
      assign prio_o[s*PRIO_W +: PRIO_W] = prio_q[s];
   end

   for (genvar w = 0; w < EN_CNT; w++) begin : g_enab
      localparam logic [31:0] MASK = word_mask(N_SRC, w % EW);
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q[w] <= '0;
         end else if (wr_i && region_i == REG_ENAB && offs_i == AW'(w)) begin
            en_q[w] <= wdata_i & MASK;
         end
      end
   end

   for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            thr_q[t] <= '0;
            swi_q[t] <= 1'b0;
         end else begin
            if (wr_i && region_i == REG_THRS && offs_i == AW'(t)) begin
               thr_q[t] <= wdata_i[PRIO_W-1:0];
            end
            if (wr_i && region_i == REG_SWIR && offs_i == AW'(t)) begin
               swi_q[t] <= wdata_i[0];
            end
         end
      end
      assign thresh_o[t*PRIO_W +: PRIO_W] = thr_q[t];
      for (genvar s = 0; s < N_SRC; s++) begin : g_bit
         assign enable_o[t*N_SRC + s] = en_q[t*EW + s/32][s%32];
      end
   end

   assign swi_o = swi_q;

   always_comb begin
      cfg_rdata_o = '0;
      case (region_i)
         REG_PRIO: begin
            for (int k = 0; k < N_SRC; k++) begin
               if (offs_i == AW'(k)) cfg_rdata_o = 32'(prio_q[k]);
            end
         end
         REG_ENAB: begin
            for (int k = 0; k < EN_CNT; k++) begin
               if (offs_i == AW'(k)) cfg_rdata_o = en_q[k];
            end
         end
         REG_THRS: begin
            for (int k = 0; k < N_TGT; k++) begin
               if (offs_i == AW'(k)) cfg_rdata_o = 32'(thr_q[k]);
            end
         end
         REG_SWIR: begin
            for (int k = 0; k < N_TGT; k++) begin
               if (offs_i == AW'(k)) cfg_rdata_o = 32'(swi_q[k]);
            end
         end
         default: cfg_rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/irqc_claim_port.sv
`timescale 1ns/1ps
module irqc_claim_port
   import irqc_pkg::*;
#(
   parameter int N_SRC = 40,
   parameter int ID_W  = 6,
   parameter int AW    = 6,
   parameter int TGT   = 0
) (
   input  logic              rd_i,
   input  logic              wr_i,
   input  reg_region_e       region_i,
   input  logic [AW-1:0]     offs_i,
   input  logic [31:0]       wdata_i,
   input  logic [ID_W-1:0]   best_id_i,
   output logic [ID_W-1:0]   rd_id_o,
   output logic              claim_o,
   output logic [ID_W-1:0]   claim_id_o,
   output logic              complete_o,
   output logic [ID_W-1:0]   complete_id_o
);

   logic sel;
   logic id_ok;

   assign sel   = (region_i == REG_CLCO) && (offs_i == AW'(TGT));
   assign id_ok = (wdata_i != 32'd0) && (wdata_i < 32'(N_SRC));

   assign rd_id_o       = (rd_i && sel) ? best_id_i : '0;
   assign claim_o       = rd_i && sel && (best_id_i != '0);
   assign claim_id_o    = claim_o ? best_id_i : '0;
   assign complete_o    = wr_i && sel && id_ok;
   assign complete_id_o = complete_o ? wdata_i[ID_W-1:0] : '0;

endmodule

// File: rtl/irqc_regs.sv
`timescale 1ns/1ps
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int N_SRC    = 40,
   parameter int N_TGT    = 2,
   parameter int MAX_PRIO = 7,
   parameter int AW       = 6,
   localparam int PRIO_W  = $clog2(MAX_PRIO + 1),
   localparam int ID_W    = $clog2(N_SRC)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      reg_we_i,
   input  logic                      reg_re_i,
   input  logic [AW-1:0]             reg_addr_i,
   input  logic [31:0]               reg_wdata_i,
   output logic [31:0]               reg_rdata_o,
   input  logic [N_SRC-1:0]          pend_i,
   input  logic [N_TGT*ID_W-1:0]     best_id_i,
   output logic [N_SRC*PRIO_W-1:0]   prio_o,
   output logic [N_TGT*N_SRC-1:0]    enable_o,
   output logic [N_TGT*PRIO_W-1:0]   thresh_o,
   output logic [N_TGT-1:0]          swi_o,
   output logic [N_TGT-1:0]          claim_o,
   output logic [N_TGT*ID_W-1:0]     claim_id_o,
   output logic [N_TGT-1:0]          complete_o,
   output logic [N_TGT*ID_W-1:0]     complete_id_o
);

   localparam int EW    = en_words(N_SRC);
   localparam int END_A = map_end(N_SRC, N_TGT);

   if (N_SRC < 2 || N_SRC > 256) begin : g_bad_nsrc
      $error("irqc_regs: N_SRC must lie in 2..256");
   end
   if (N_TGT < 1) begin : g_bad_ntgt
      $error("irqc_regs: N_TGT must be at least 1");
   end
   if (MAX_PRIO < 1 || PRIO_W > 32) begin : g_bad_prio
      $error("irqc_regs: MAX_PRIO out of range");
   end
   if (AW < 1 || AW > 30 || END_A > (1 << AW)) begin : g_bad_aw
      $error("irqc_regs: AW too small for the register map");
   end

   reg_region_e     region;
   logic [AW-1:0]   offs;
   logic [31:0]     cfg_rdata;
   logic [ID_W-1:0] cc_rd [N_TGT];
   logic [EW*32-1:0] pend_pad;

   assign pend_pad = (EW*32)'(pend_i);

   irqc_addr_map #(.N_SRC(N_SRC), .N_TGT(N_TGT), .AW(AW)) u_map (
      .addr_i   (reg_addr_i),
      .region_o (region),
      .offs_o   (offs)
   );

   irqc_cfg_store #(.N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W), .AW(AW)) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (reg_we_i),
      .region_i    (region),
      .offs_i      (offs),
      .wdata_i     (reg_wdata_i),
      .cfg_rdata_o (cfg_rdata),
      .prio_o      (prio_o),
      .enable_o    (enable_o),
      .thresh_o    (thresh_o),
      .swi_o       (swi_o)
   );

   for (genvar t = 0; t < N_TGT; t++) begin : g_cc
      irqc_claim_port #(.N_SRC(N_SRC), .ID_W(ID_W), .AW(AW), .TGT(t)) u_port (
         .rd_i          (reg_re_i),
         .wr_i          (reg_we_i),
         .region_i      (region),
         .offs_i        (offs),
         .wdata_i       (reg_wdata_i),
         .best_id_i     (best_id_i[t*ID_W +: ID_W]),
         .rd_id_o       (cc_rd[t]),
         .claim_o       (claim_o[t]),
         .claim_id_o    (claim_id_o[t*ID_W +: ID_W]),
         .complete_o    (complete_o[t]),
         .complete_id_o (complete_id_o[t*ID_W +: ID_W])
      );
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_re_i) begin
         case (region)
            REG_PEND: begin
               for (int w = 0; w < EW; w++) begin
                  if (offs == AW'(w)) reg_rdata_o = pend_pad[w*32 +: 32];
               end
            end
            REG_CLCO: begin
               for (int t = 0; t < N_TGT; t++) begin
                  reg_rdata_o = reg_rdata_o | 32'(cc_rd[t]);
               end
            end
            default: reg_rdata_o = cfg_rdata;
         endcase
      end
   end

endmodule

// File: rtl/irqc_regs_chk.sv
`timescale 1ns/1ps
module irqc_regs_chk
   import irqc_pkg::*;
#(
   parameter int N_SRC    = 40,
   parameter int N_TGT    = 2,
   parameter int MAX_PRIO = 7,
   parameter int AW       = 6,
   localparam int PRIO_W  = $clog2(MAX_PRIO + 1),
   localparam int ID_W    = $clog2(N_SRC)
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      reg_we_i,
   input logic                      reg_re_i,
   input logic [AW-1:0]             reg_addr_i,
   input logic [31:0]               reg_wdata_i,
   input logic [31:0]               reg_rdata_o,
   input logic [N_SRC*PRIO_W-1:0]   prio_o,
   input logic [N_TGT*N_SRC-1:0]    enable_o,
   input logic [N_TGT*PRIO_W-1:0]   thresh_o,
   input logic [N_TGT-1:0]          swi_o,
   input logic [N_TGT-1:0]          claim_o,
   input logic [N_TGT*ID_W-1:0]     claim_id_o,
   input logic [N_TGT-1:0]          complete_o,
   input logic [N_TGT*ID_W-1:0]     complete_id_o
);

   localparam int PEND_B = pend_base(N_SRC, N_TGT);
   localparam int END_A  = map_end(N_SRC, N_TGT);

   logic pend_wr;
   assign pend_wr = reg_we_i && (32'(reg_addr_i) >= 32'(PEND_B));

   AST_ONE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(claim_o)); // R6

   AST_NO_STROBE_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_re_i |-> reg_rdata_o == 32'd0); // R11

   AST_CFG_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_we_i |=> $stable(prio_o) && $stable(enable_o) && $stable(thresh_o) && $stable(swi_o)); // R11

   AST_PEND_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_wr |=> $stable(prio_o) && $stable(enable_o) && $stable(thresh_o) && $stable(swi_o)); // R5

   for (genvar t = 0; t < N_TGT; t++) begin : g_t
      AST_CLAIM_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
         claim_o[t] |-> reg_re_i && reg_rdata_o == 32'(claim_id_o[t*ID_W +: ID_W])); // R6

      AST_CLAIM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         claim_o[t] |-> claim_id_o[t*ID_W +: ID_W] != '0); // R7

      AST_COMPLETE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         complete_o[t] |-> reg_we_i && 32'(complete_id_o[t*ID_W +: ID_W]) == reg_wdata_i); // R8

      AST_COMPLETE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         complete_o[t] |-> reg_wdata_i != 32'd0 && reg_wdata_i < 32'(N_SRC)); // R8

      AST_COMPLETE_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
         complete_o[t] |=> $stable(prio_o) && $stable(enable_o) && $stable(thresh_o) && $stable(swi_o)); // R8
   end

endmodule

bind irqc_regs irqc_regs_chk #(
   .N_SRC(N_SRC), .N_TGT(N_TGT), .MAX_PRIO(MAX_PRIO), .AW(AW)
) u_chk (.*);

// File: tb/irqc_regs_tb.sv
`timescale 1ns/1ps
module irqc_regs_tb;

   localparam int N      = 40;
   localparam int T      = 2;
   localparam int MP     = 7;
   localparam int AW     = 6;
   localparam int PW     = 3;
   localparam int IW     = 6;
   localparam int EW     = 2;
   localparam int EN_B   = 40;
   localparam int THR_B  = 44;
   localparam int CC_B   = 46;
   localparam int SWI_B  = 48;
   localparam int PEND_B = 50;
   localparam int END_A  = 52;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            we = 1'b0;
   logic            re = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [N-1:0]    pend = '0;
   logic [T*IW-1:0] bid = '0;
   logic [N*PW-1:0] prio;
   logic [T*N-1:0]  enab;
   logic [T*PW-1:0] thr;
   logic [T-1:0]    swi;
   logic [T-1:0]    claim;
   logic [T*IW-1:0] claim_id;
   logic [T-1:0]    cmpl;
   logic [T*IW-1:0] cmpl_id;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int m_prio [N];
   bit m_en   [T][N];
   int m_thr  [T];
   bit m_swi  [T];

   always #2.5 clk = ~clk;

   irqc_regs #(.N_SRC(N), .N_TGT(T), .MAX_PRIO(MP), .AW(AW)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_re_i (re),
      .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
      .pend_i (pend), .best_id_i (bid), .prio_o (prio), .enable_o (enab),
      .thresh_o (thr), .swi_o (swi), .claim_o (claim), .claim_id_o (claim_id),
      .complete_o (cmpl), .complete_id_o (cmpl_id)
   );

   task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int bid_of(int t);
      return int'(bid[t*IW +: IW]);
   endfunction

   function automatic logic [31:0] mread(int a);
      logic [31:0] r = '0;
      if (a < EN_B) r = 32'(m_prio[a]);
      else if (a < THR_B) begin
         for (int b = 0; b < 32; b++) begin
            int s = ((a - EN_B) % EW) * 32 + b;
            if (s < N) r[b] = m_en[(a - EN_B) / EW][s];
         end
      end
      else if (a < CC_B) r = 32'(m_thr[a - THR_B]);
      else if (a < SWI_B) r = 32'(bid_of(a - CC_B));
      else if (a < PEND_B) r = 32'(m_swi[a - SWI_B]);
      else if (a < END_A) begin
         for (int b = 0; b < 32; b++) begin
            int s = (a - PEND_B) * 32 + b;
            if (s < N) r[b] = pend[s];
         end
      end
      return r;
   endfunction

   task automatic mwrite(int a, logic [31:0] d);
      if (a < EN_B) m_prio[a] = int'(d % (MP + 1));
      else if (a < THR_B) begin
         for (int b = 0; b < 32; b++) begin
            int s = ((a - EN_B) % EW) * 32 + b;
            if (s < N) m_en[(a - EN_B) / EW][s] = d[b];
         end
      end
      else if (a < CC_B) m_thr[a - THR_B] = int'(d % (MP + 1));
      else if (a >= SWI_B && a < PEND_B) m_swi[a - SWI_B] = d[0];
   endtask

   function automatic string tag_of(int a);
      if (a < EN_B) return "R2";
      if (a < THR_B) return "R3";
      if (a < CC_B) return "R4";
      if (a < SWI_B) return "R6";
      if (a < PEND_B) return "R9";
      if (a < END_A) return "R5";
      return "R10";
   endfunction

   // one bus cycle: drive at the falling edge, check combinational outputs, model at the rising edge
   task automatic bus(bit w, bit r, int a, logic [31:0] d, string tag);
      logic [T-1:0]    e_cl  = '0;
      logic [T*IW-1:0] e_cid = '0;
      logic [T-1:0]    e_co  = '0;
      logic [T*IW-1:0] e_coid = '0;
      @(negedge clk);
      we = w; re = r; addr = AW'(a); wdata = d;
      #1;
      for (int t = 0; t < T; t++) begin
         if (r && a == CC_B + t && bid_of(t) != 0) begin
            e_cl[t] = 1'b1;
            e_cid[t*IW +: IW] = IW'(bid_of(t));
         end
         if (w && a == CC_B + t && d != 0 && d < 32'(N)) begin
            e_co[t] = 1'b1;
            e_coid[t*IW +: IW] = d[IW-1:0];
         end
      end
      chk({tag, " rdata"}, rdata, r ? mread(a) : 32'd0);
      chk({tag, " claim_o"}, claim, e_cl);
      chk({tag, " claim_id_o"}, claim_id, e_cid);
      chk({tag, " complete_o"}, cmpl, e_co);
      chk({tag, " complete_id_o"}, cmpl_id, e_coid);
      @(posedge clk);
      if (w) mwrite(a, d);
   endtask

   // stored state compared with the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [N*PW-1:0] e_p;
         logic [T*N-1:0]  e_e;
         logic [T*PW-1:0] e_t;
         logic [T-1:0]    e_s;
         for (int k = 0; k < N; k++) e_p[k*PW +: PW] = PW'(m_prio[k]);
         for (int t = 0; t < T; t++) begin
            for (int s = 0; s < N; s++) e_e[t*N + s] = m_en[t][s];
            e_t[t*PW +: PW] = PW'(m_thr[t]);
            e_s[t] = m_swi[t];
         end
         chk("R2 prio_o", prio, e_p);
         chk("R3 enable_o", enab, e_e);
         chk("R4 thresh_o", thr, e_t);
         chk("R9 swi_o", swi, e_s);
      end
   end

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < N; k++) m_prio[k] = 0;
      for (int t = 0; t < T; t++) begin
         m_thr[t] = 0; m_swi[t] = 0;
         for (int s = 0; s < N; s++) m_en[t][s] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 prio_o", prio, '0);
      chk("R1 enable_o", enab, '0);
      chk("R1 thresh_o", thr, '0);
      chk("R1 swi_o", swi, '0);
      bus(0, 1, 5, 0, "R1");
      bus(0, 1, EN_B + 1, 0, "R1");
      bus(0, 1, THR_B, 0, "R1");
      // R2: priorities truncated to PW bits, shared
      bus(1, 0, 1, 32'd5, "R2");
      bus(1, 0, 39, 32'hFF, "R2");
      bus(1, 0, 0, 32'd3, "R2");
      bus(0, 1, 39, 0, "R2");
      bus(0, 1, 1, 0, "R2");
      // R3: enable word layout incl. partial last word
      bus(1, 0, EN_B + 0, 32'h8000_0002, "R3");
      bus(1, 0, EN_B + 1, 32'hFFFF_FFFF, "R3");
      bus(1, 0, EN_B + 2, 32'h0000_0010, "R3");
      bus(1, 0, EN_B + 3, 32'h0000_0081, "R3");
      bus(0, 1, EN_B + 1, 0, "R3");
      bus(0, 1, EN_B + 3, 0, "R3");
      // R4: thresholds
      bus(1, 0, THR_B, 32'd6, "R4");
      bus(1, 0, THR_B + 1, 32'h1F, "R4");
      bus(0, 1, THR_B + 1, 0, "R4");
      // R5: pending view, read-only
      pend = 40'hA5_0000_1234;
      bus(0, 1, PEND_B, 0, "R5");
      bus(0, 1, PEND_B + 1, 0, "R5");
      bus(1, 0, PEND_B, 32'hFFFF_FFFF, "R5");
      bus(1, 0, PEND_B + 1, 32'hFFFF_FFFF, "R5");
      bus(0, 1, PEND_B + 1, 0, "R5");
      // R6 / R7: claim reads
      bid = {6'd0, 6'd17};
      bus(0, 1, CC_B, 0, "R6");
      bus(0, 1, CC_B + 1, 0, "R7");
      bid = {6'd39, 6'd0};
      bus(0, 1, CC_B + 1, 0, "R6");
      bus(0, 1, CC_B, 0, "R7");
      // R8: completion writes, valid and invalid IDs
      bus(1, 0, CC_B, 32'd17, "R8");
      bus(1, 0, CC_B + 1, 32'd1, "R8");
      bus(1, 0, CC_B, 32'd0, "R8");
      bus(1, 0, CC_B + 1, 32'd40, "R8");
      bus(1, 0, CC_B, 32'h0000_0101, "R8");
      bus(1, 0, CC_B + 1, 32'd39, "R8");
      // R9: software interrupt bits
      bus(1, 0, SWI_B + 1, 32'hFFFF_FFFF, "R9");
      bus(0, 1, SWI_B + 1, 0, "R9");
      bus(1, 0, SWI_B, 32'h2, "R9");
      bus(1, 0, SWI_B + 1, 32'h0, "R9");
      // R10: unmapped addresses
      bus(1, 0, END_A, 32'hFFFF_FFFF, "R10");
      bus(1, 0, 63, 32'hFFFF_FFFF, "R10");
      bus(0, 1, 63, 0, "R10");
      bus(0, 1, END_A + 3, 0, "R10");
      // R11: idle cycles and reads without side effect
      bid = {6'd9, 6'd33};
      bus(0, 0, CC_B, 32'd9, "R11");
      bus(0, 0, CC_B + 1, 32'd9, "R11");
      bus(0, 1, 2, 0, "R11");
      // mixed traffic
      for (int i = 0; i < 600; i++) begin
         int a = int'($urandom_range(0, 63));
         bit w = $urandom_range(0, 1) == 1;
         bit r = !w && ($urandom_range(0, 3) != 0);
         logic [31:0] d = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 45)) : $urandom;
         pend = {8'($urandom), 32'($urandom)};
         bid = {6'($urandom_range(0, 39)), 6'($urandom_range(0, 39))};
         bus(w, r, a, d, tag_of(a));
      end
      bus(0, 0, 0, 0, "R11");
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule